// File: doc/BRIEF.md
# Mailbox Endpoint with Level-Threshold Interrupts

This block is one endpoint of a word mailbox that carries 32-bit messages between two processors. The local processor reaches it through a small register port. Writing the data-in register queues a word on an outbound FIFO. Reading the data-out register takes the oldest word from an inbound FIFO. The far processor sits on plain push and pop ports: it drains the outbound FIFO and fills the inbound one.

Two programmable thresholds compare the FIFO levels and feed three interrupt sources: outbound level, inbound level, and error. Each source has a sticky state bit, an enable bit and a test bit, and its output line is gated by the enable. The outbound comparison fires while the level is *above* its threshold, so it signals that the queue is busy, not that it has room. The inbound comparison is strict greater-than, so a threshold of zero means "at least one word waiting". Software that wants to send therefore polls the full flag. Overflow and underflow are recorded in an error register that clears when read. A control write flushes both queues.

Top module: `mbx_endpoint`

## Requirements
- R1: After reset, interrupt state, enable, error and both thresholds read 0, status reads 0x1, all three interrupt lines are low, `peer_empty` is 1 and `peer_full` is 0.
- R2: Each write to offset 0x0C queues its data on the outbound FIFO. The peer reads the words in write order on `peer_rdata` and removes each with `peer_pop`. `peer_empty` is 1 when nothing is queued.
- R3: A write to 0x0C while the outbound FIFO already holds DEPTH (8) words is dropped. It sets error bit 0 (overflow) and interrupt state bit 2.
- R4: A read of 0x10 while the inbound FIFO is empty returns 0. It sets error bit 1 (underflow) and interrupt state bit 2.
- R5: Words pushed by the peer come out of reads of 0x10 in push order. `peer_full` is 1 when the inbound FIFO holds 8 words.
- R6: Interrupt state bit 1 becomes set when the inbound level is strictly greater than the read threshold at 0x20. A threshold of 0 therefore sets it for any nonempty inbound FIFO.
- R7: Interrupt state bit 0 becomes set when the outbound level is strictly greater than the write threshold at 0x1C.
- R8: Writing 1s to the interrupt state register (0x00) clears those bits, and 0 bits are left unchanged. A bit whose condition is still true is set again, so it reads back as 1.
- R9: `irq_wthr`, `irq_rthr` and `irq_err` follow interrupt state bits 0, 1 and 2 only while enable bits 0, 1 and 2 at 0x04 are set.
- R10: Writing 1s to the interrupt test register (0x08) sets those interrupt state bits, whatever the FIFO levels. The error register is not affected.
- R11: Writing control offset 0x24 with bit 0 set empties both FIFOs.
- R12: Reading the error register (0x18) returns its bits and clears them.
- R13: The status register (0x14) holds: bit 0 inbound empty, bit 1 outbound full, bit 2 outbound level above the write threshold, bit 3 inbound level above the read threshold. Write-only offsets (0x0C, 0x24) read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Register access request, held until `bus_ready` |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | One-cycle completion pulse, read data valid with it |
| bus_rdata | output | 32 | Read data |
| peer_push | input | 1 | Peer pushes a word into the inbound FIFO |
| peer_wdata | input | 32 | Word pushed by the peer |
| peer_full | output | 1 | Inbound FIFO full; pushes are ignored |
| peer_pop | input | 1 | Peer removes the head of the outbound FIFO |
| peer_rdata | output | 32 | Head of the outbound FIFO |
| peer_empty | output | 1 | Outbound FIFO empty |
| irq_wthr | output | 1 | Outbound level interrupt line |
| irq_rthr | output | 1 | Inbound level interrupt line |
| irq_err | output | 1 | Error interrupt line |

## Verification
The bench writes a ninth word into a full outbound queue. A design that stored the word or wrapped its pointer would show a corrupted word or an extra word at the peer, and a missing overflow flag. It reads an empty inbound queue, where a wrong design would return stale data or no underflow flag. It sets the read threshold to 2 and checks the bit stays clear at two words and sets at three; a greater-or-equal comparison would set it one word early. It clears a state bit whose condition persists and one whose condition is gone, which separates a sticky bit from a plain level copy. It also checks that test writes leave the error register alone and that a flush really empties both queues.

// File: rtl/mbx_pkg.sv
// Shared constants for the mailbox endpoint: register offsets and the bit
// positions inside the interrupt and status registers.
package mbx_pkg;
    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] OFS_ISTATE = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_IEN    = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_ITEST  = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_DIN    = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_DOUT   = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_ERR    = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_WTHR   = 6'h1C;
    localparam logic [ADDR_W-1:0] OFS_RTHR   = 6'h20;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 6'h24;

    localparam int NUM_IRQ = 3;
    localparam int IRQ_WT  = 0;
    localparam int IRQ_RT  = 1;
    localparam int IRQ_ER  = 2;

    localparam int ERR_OVF = 0;
    localparam int ERR_UNF = 1;
endpackage

// File: rtl/mbx_fifo.sv
// Word FIFO for one direction of the mailbox.
// Assumes: DEPTH is a power of two, and the caller never pushes while full
// nor pops while empty. A flush wins over a push or pop in the same cycle.
module mbx_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    input  logic              flush,
    output logic [DATA_W-1:0] head,
    output logic [LVL_W-1:0]  level,
    output logic              full,
    output logic              empty
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [LVL_W-1:0]  count;

    // Storage write; the contents need no reset.
    always_ff @(posedge clk) begin
        if (push && !flush) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Flags and head word.
    always_comb begin
        head  = mem[rd_ptr];
        level = count;
        full  = (count == LVL_W'(DEPTH));
        empty = (count == '0);
    end

    assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LVL_W'(DEPTH));
    assert_no_push_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_no_pop_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    assert_flush_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);
endmodule

// File: rtl/mbx_irq.sv
// Sticky interrupt state with write-1-to-clear, test and enable gating.
// Assumes: events and test bits are single-cycle qualifiers; a set in the
// same cycle as a clear wins, so a persisting condition re-arms its bit.
module mbx_irq #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] test,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] en,
    output logic [N-1:0] state,
    output logic [N-1:0] irq
);
    logic [N-1:0] state_q;

    // Update pending bits: clear first, then merge new events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= (state_q & ~clr) | evt | test;
        end
    end

    // Enabled pending bits drive the lines.
    always_comb begin
        state = state_q;
        irq   = state_q & en;
    end

    assert_test_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (test != '0) |=> ((state_q & $past(test)) == $past(test)));
    assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr & ~evt & ~test) != '0) |=> ((state_q & $past(clr & ~evt & ~test)) == '0));
endmodule

// File: rtl/mbx_endpoint.sv
// Mailbox endpoint: register decode, two FIFOs, thresholds, error capture and
// interrupt logic. Assumes the bus master holds bus_req until bus_ready and
// uses word-aligned byte offsets; unmapped offsets read 0, writes are ignored.
module mbx_endpoint
    import mbx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ready,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              peer_push,
    input  logic [DATA_W-1:0] peer_wdata,
    output logic              peer_full,
    input  logic              peer_pop,
    output logic [DATA_W-1:0] peer_rdata,
    output logic              peer_empty,
    output logic              irq_wthr,
    output logic              irq_rthr,
    output logic              irq_err
);
    logic              accept, wr, rd;
    logic              out_push, out_pop, in_push, in_pop, flush;
    logic              out_full, out_empty, in_full, in_empty;
    logic [LVL_W-1:0]  out_level, in_level;
    logic [DATA_W-1:0] in_head, rdata_d;
    logic [LVL_W-1:0]  wthr_q, rthr_q;
    logic [1:0]        err_q;
    logic [NUM_IRQ-1:0] ien_q, istate, irq_vec, irq_evt, irq_test, irq_clr;
    logic              ovf_evt, unf_evt, wt_cond, rt_cond, ready_q;

    // Access qualification: one access per request, completed next cycle.
    always_comb begin
        accept = bus_req && !ready_q;
        wr     = accept && bus_we;
        rd     = accept && !bus_we;
    end

    // FIFO controls and error events.
    always_comb begin
        flush    = wr && (bus_addr == OFS_CTRL) && bus_wdata[0];
        out_push = wr && (bus_addr == OFS_DIN) && !out_full;
        ovf_evt  = wr && (bus_addr == OFS_DIN) && out_full;
        out_pop  = peer_pop && !out_empty;
        in_push  = peer_push && !in_full;
        in_pop   = rd && (bus_addr == OFS_DOUT) && !in_empty;
        unf_evt  = rd && (bus_addr == OFS_DOUT) && in_empty;
    end

    mbx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_out_fifo (
        .clk(clk), .rst_n(rst_n), .push(out_push), .push_data(bus_wdata),
        .pop(out_pop), .flush(flush), .head(peer_rdata), .level(out_level),
        .full(out_full), .empty(out_empty)
    );

    mbx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_in_fifo (
        .clk(clk), .rst_n(rst_n), .push(in_push), .push_data(peer_wdata),
        .pop(in_pop), .flush(flush), .head(in_head), .level(in_level),
        .full(in_full), .empty(in_empty)
    );

    // Threshold comparisons (strictly greater than).
    always_comb begin
        wt_cond = out_level > wthr_q;
        rt_cond = in_level > rthr_q;
    end

    // Software-visible configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wthr_q <= '0;
            rthr_q <= '0;
            ien_q  <= '0;
        end else if (wr) begin
            if (bus_addr == OFS_WTHR) wthr_q <= bus_wdata[LVL_W-1:0];
            if (bus_addr == OFS_RTHR) rthr_q <= bus_wdata[LVL_W-1:0];
            if (bus_addr == OFS_IEN)  ien_q  <= bus_wdata[NUM_IRQ-1:0];
        end
    end

    // Error capture; a read clears, a new event in the same cycle survives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= '0;
        end else begin
            err_q <= ((rd && bus_addr == OFS_ERR) ? 2'b00 : err_q)
                     | {unf_evt, ovf_evt};
        end
    end

    // Interrupt inputs from conditions and register writes.
    always_comb begin
        irq_evt          = '0;
        irq_evt[IRQ_WT]  = wt_cond;
        irq_evt[IRQ_RT]  = rt_cond;
        irq_evt[IRQ_ER]  = ovf_evt || unf_evt;
        irq_test = (wr && bus_addr == OFS_ITEST)  ? bus_wdata[NUM_IRQ-1:0] : '0;
        irq_clr  = (wr && bus_addr == OFS_ISTATE) ? bus_wdata[NUM_IRQ-1:0] : '0;
    end

    mbx_irq #(.N(NUM_IRQ)) u_irq (
        .clk(clk), .rst_n(rst_n), .evt(irq_evt), .test(irq_test),
        .clr(irq_clr), .en(ien_q), .state(istate), .irq(irq_vec)
    );

    // Read data selection.
    always_comb begin
        rdata_d = '0;
        case (bus_addr)
            OFS_ISTATE: rdata_d = DATA_W'(istate);
            OFS_IEN:    rdata_d = DATA_W'(ien_q);
            OFS_DOUT:   rdata_d = in_empty ? '0 : in_head;
            OFS_STAT:   rdata_d = DATA_W'({rt_cond, wt_cond, out_full, in_empty});
            OFS_ERR:    rdata_d = DATA_W'(err_q);
            OFS_WTHR:   rdata_d = DATA_W'(wthr_q);
            OFS_RTHR:   rdata_d = DATA_W'(rthr_q);
            default:    rdata_d = '0;
        endcase
    end

    // Registered bus response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q   <= 1'b0;
            bus_rdata <= '0;
        end else begin
            ready_q   <= accept;
            bus_rdata <= rd ? rdata_d : '0;
        end
    end

    // Port outputs.
    always_comb begin
        bus_ready  = ready_q;
        peer_full  = in_full;
        peer_empty = out_empty;
        irq_wthr   = irq_vec[IRQ_WT];
        irq_rthr   = irq_vec[IRQ_RT];
        irq_err    = irq_vec[IRQ_ER];
    end

    assert_overflow_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> (err_q[ERR_OVF] && istate[IRQ_ER]));
    assert_underflow_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        unf_evt |=> (err_q[ERR_UNF] && istate[IRQ_ER] && bus_rdata == '0));
    assert_rthr_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rthr_q == '0 && !in_empty) |=> istate[IRQ_RT]);
    assert_wthr_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wt_cond |=> istate[IRQ_WT]);
    assert_line_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_rthr |-> ien_q[IRQ_RT]) and (irq_wthr |-> ien_q[IRQ_WT])
        and (irq_err |-> ien_q[IRQ_ER]));
    assert_err_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && bus_addr == OFS_ERR && !ovf_evt && !unf_evt) |=> (err_q == 2'b00));
endmodule

// File: tb/test_mbx_endpoint.sv
// Self-checking bench: a register vector table, then directed corner cases.
module test_mbx_endpoint;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam int NVEC       = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready;
    logic [31:0] bus_rdata;
    logic        peer_push = 1'b0, peer_pop = 1'b0;
    logic [31:0] peer_wdata = '0;
    logic        peer_full, peer_empty;
    logic [31:0] peer_rdata;
    logic        irq_wthr, irq_rthr, irq_err;

    int checks = 0;
    int errors = 0;
    logic [31:0] q;

    // Vector: {check, write, offset, wdata, expected read}
    localparam logic [71:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 6'h14, 32'h0,  32'h1},   // R13 reset status
        {1'b1, 1'b0, 6'h00, 32'h0,  32'h0},   // R1 istate
        {1'b1, 1'b0, 6'h18, 32'h0,  32'h0},   // R1 error
        {1'b0, 1'b1, 6'h1C, 32'h2,  32'h0},   // wthr = 2
        {1'b1, 1'b0, 6'h1C, 32'h0,  32'h2},   // R7 readback
        {1'b0, 1'b1, 6'h0C, 32'hA1, 32'h0},
        {1'b0, 1'b1, 6'h0C, 32'hA2, 32'h0},
        {1'b0, 1'b1, 6'h0C, 32'hA3, 32'h0},
        {1'b1, 1'b0, 6'h14, 32'h0,  32'h5},   // R13 status with level 3 > 2
        {1'b1, 1'b0, 6'h00, 32'h0,  32'h1},   // R7 pending
        {1'b1, 1'b0, 6'h0C, 32'h0,  32'h0},   // R13 write-only reads 0
        {1'b0, 1'b1, 6'h08, 32'h4,  32'h0},   // test error bit
        {1'b1, 1'b0, 6'h00, 32'h0,  32'h5},   // R10
        {1'b0, 1'b1, 6'h00, 32'h4,  32'h0},   // clear error bit
        {1'b1, 1'b0, 6'h00, 32'h0,  32'h1},   // R8 bit0 stays
        {1'b1, 1'b0, 6'h18, 32'h0,  32'h0}    // R10 error untouched
    };
    string vtag [NVEC] = '{"R13", "R1", "R1", "-", "R7", "-", "-", "-",
                           "R13", "R7", "R13", "-", "R10", "-", "R8", "R10"};

    mbx_endpoint i_mbx_endpoint (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_rdata(bus_rdata), .peer_push(peer_push), .peer_wdata(peer_wdata),
        .peer_full(peer_full), .peer_pop(peer_pop), .peer_rdata(peer_rdata),
        .peer_empty(peer_empty), .irq_wthr(irq_wthr), .irq_rthr(irq_rthr),
        .irq_err(irq_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FIL-less mismatch guard");
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic bus(input logic we, input logic [5:0] a, input logic [31:0] d,
                       output logic [31:0] r);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        while (!bus_ready) @(negedge clk);
        r = bus_rdata;
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic push_peer(input logic [31:0] d);
        @(negedge clk);
        peer_push = 1'b1; peer_wdata = d;
        @(negedge clk);
        peer_push = 1'b0;
    endtask

    task automatic pop_peer(input string tag, input logic [31:0] exp);
        @(negedge clk);
        check(tag, peer_rdata, exp);
        peer_pop = 1'b1;
        @(negedge clk);
        peer_pop = 1'b0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state at the ports
        check("R1", {irq_wthr, irq_rthr, irq_err}, 32'h0);
        check("R1", peer_empty, 32'h1);
        check("R1", peer_full, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            bus(VEC[i][70], VEC[i][69:64], VEC[i][63:32], q);
            if (VEC[i][71]) check(vtag[i], q, VEC[i][31:0]);
        end

        // R2 peer drains in order; R9 lines stay low with enables off
        check("R9", irq_wthr, 32'h0);
        pop_peer("R2", 32'hA1);
        pop_peer("R2", 32'hA2);
        pop_peer("R2", 32'hA3);
        check("R2", peer_empty, 32'h1);
        bus(1'b1, 6'h00, 32'h1, q);
        bus(1'b0, 6'h00, 32'h0, q);
        check("R8", q, 32'h0);

        // R3 overflow: ninth word dropped
        for (int i = 0; i < 9; i++) bus(1'b1, 6'h0C, 32'h100 + i, q);
        bus(1'b0, 6'h18, 32'h0, q);
        check("R3", q, 32'h1);
        bus(1'b0, 6'h18, 32'h0, q);
        check("R12", q, 32'h0);
        bus(1'b0, 6'h00, 32'h0, q);
        check("R3", q, 32'h5);
        bus(1'b0, 6'h14, 32'h0, q);
        check("R13", q, 32'h7);
        for (int i = 0; i < 8; i++) pop_peer("R3", 32'h100 + i);
        check("R3", peer_empty, 32'h1);

        // R4 underflow
        bus(1'b0, 6'h10, 32'h0, q);
        check("R4", q, 32'h0);
        bus(1'b0, 6'h18, 32'h0, q);
        check("R4", q, 32'h2);
        bus(1'b1, 6'h00, 32'h7, q);
        bus(1'b0, 6'h00, 32'h0, q);
        check("R8", q, 32'h0);

        // R6 threshold 0 means nonempty; R9 enable gating
        push_peer(32'h55);
        bus(1'b0, 6'h00, 32'h0, q);
        check("R6", q, 32'h2);
        bus(1'b1, 6'h04, 32'h2, q);
        check("R9", irq_rthr, 32'h1);
        check("R9", irq_wthr, 32'h0);
        bus(1'b0, 6'h10, 32'h0, q);
        check("R5", q, 32'h55);
        bus(1'b1, 6'h00, 32'h2, q);
        bus(1'b0, 6'h00, 32'h0, q);
        check("R8", q, 32'h0);
        check("R9", irq_rthr, 32'h0);
        bus(1'b1, 6'h04, 32'h0, q);

        // R6 strict comparison at threshold 2
        bus(1'b1, 6'h20, 32'h2, q);
        push_peer(32'h61);
        push_peer(32'h62);
        bus(1'b1, 6'h00, 32'h2, q);
        bus(1'b0, 6'h00, 32'h0, q);
        check("R6", q, 32'h0);
        push_peer(32'h63);
        bus(1'b0, 6'h00, 32'h0, q);
        check("R6", q, 32'h2);
        bus(1'b0, 6'h14, 32'h0, q);
        check("R13", q, 32'h8);
        for (int i = 0; i < 3; i++) begin
            bus(1'b0, 6'h10, 32'h0, q);
            check("R5", q, 32'h61 + i);
        end

        // R11 flush both directions
        bus(1'b1, 6'h0C, 32'hB1, q);
        push_peer(32'hC1);
        push_peer(32'hC2);
        bus(1'b1, 6'h24, 32'h1, q);
        bus(1'b0, 6'h14, 32'h0, q);
        check("R11", q, 32'h1);
        check("R11", peer_empty, 32'h1);
        bus(1'b0, 6'h10, 32'h0, q);
        check("R11", q, 32'h0);

        // R5 inbound full indication
        for (int i = 0; i < 8; i++) push_peer(32'hD0 + i);
        check("R5", peer_full, 32'h1);
        push_peer(32'hEE);
        bus(1'b0, 6'h10, 32'h0, q);
        check("R5", q, 32'hD0);

        finish_run();
    end
endmodule